// File: doc/BRIEF.md
# ECC Error Status and Capture

This block sits next to an ECC-protected RAM and an ECC-protected flash. Each memory's checker sends one-cycle pulses when it corrects a single-bit error or finds an error it cannot correct. With each pulse it also sends the faulting address, the bus attributes, the requesting master and the data. The RAM side also sends a syndrome. The block keeps four sticky flags, one per event type. Each flag has its own report enable. The flags drive a single interrupt request. The details of an accepted event are stored in a capture bank for that memory. When several enabled events arrive in the same cycle, a fixed priority picks the one whose details are stored.

Software reaches the block through a small register port. Writes are single-cycle strobes. Reads are combinational. The enable register and the status register share one bit layout, and status flags are cleared by writing ones.

The interrupt request comes from a two-state machine. `IRQ_IDLE` means no flag is set. The *raise* transition goes to `IRQ_PEND` whenever the next flag value has any bit set. The *drop* transition goes back to `IRQ_IDLE` once the next flag value is all clear. The request is high exactly in `IRQ_PEND`.

Top module: `ecc_err_report`

Register addresses (3-bit `reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | report enables | read/write |
| 1 | status flags | read, write 1 to clear |
| 2 | RAM fault address | read only |
| 3 | RAM fault info | read only |
| 4 | RAM fault data | read only |
| 5 | flash fault address | read only |
| 6 | flash fault info | read only |
| 7 | flash fault data | read only |

## Requirements
- R1: After reset, all eight registers read zero and `irq` is low.
- R2: The status register and the enable register share one layout. Bit 5 is RAM single-bit, bit 4 is flash single-bit, bit 1 is RAM uncorrectable and bit 0 is flash uncorrectable. Writing 0xFF to the enable register reads back 0x33, and every other bit of both registers reads zero.
- R3: An event pulse sets its flag at the next clock edge only if its enable bit is 1. With the enable bit at 0, the flag stays clear and the capture registers do not change.
- R4: Writing the status register clears each flag whose write-data bit is 1. Flags written with 0 keep their value, and a flag never clears without such a write.
- R5: `irq` is high in the same cycle as any status flag and falls only when every flag has been cleared.
- R6: If a write-1 clear and an accepted event hit the same flag in the same cycle, the flag ends up set.
- R7: An accepted RAM event stores its address, its info word and its data. The info word is {syndrome[7:0], master[3:0], attr[7:0]}, zero-extended. An accepted flash event stores its address, its info word {master[3:0], attr[7:0]} (zero-extended) and its data.
- R8: When several accepted events share a cycle, all of their flags are set. Only the winner's details are stored, in the priority order RAM single-bit, flash single-bit, RAM uncorrectable, flash uncorrectable. The other memory's capture bank is unchanged.
- R9: Each newly accepted winning event overwrites its memory's capture bank. The bank holds its value at all other times.
- R10: Writes to addresses 2 to 7 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data (enable / status layout) |
| reg_rdata | output | RW (32) | Read data for `reg_addr` |
| ram_cor | input | 1 | RAM single-bit correction pulse |
| ram_unc | input | 1 | RAM uncorrectable error pulse |
| ram_addr | input | ADDR_W (32) | RAM faulting address |
| ram_attr | input | ATTR_W (8) | RAM access attributes |
| ram_mstr | input | MSTR_W (4) | RAM requesting master |
| ram_syn | input | SYN_W (8) | RAM ECC syndrome |
| ram_data | input | DATA_W (32) | RAM faulting data |
| fl_cor | input | 1 | Flash single-bit correction pulse |
| fl_unc | input | 1 | Flash uncorrectable error pulse |
| fl_addr | input | ADDR_W (32) | Flash faulting address |
| fl_attr | input | ATTR_W (8) | Flash access attributes |
| fl_mstr | input | MSTR_W (4) | Flash requesting master |
| fl_data | input | DATA_W (32) | Flash faulting data |
| irq | output | 1 | ECC interrupt request |

## Verification
The bench targets the following corner cases:

- **Clear and event in the same cycle.** A design that lets the clear win would lose an error report and leave `irq` low while an error is outstanding.
- **Events from both memories in the same cycle.** A design that ranks them wrongly would store the wrong memory's details, or would update both banks.
- **Disabled events.** A design that drops the enable gating on the capture path would overwrite the stored details while the flag stays clear.
- **Partial clears and write-0 bits.** These expose an interrupt that falls too early, or flags that get cleared by a zero.
- **Writes to read-only addresses.** These expose capture banks that can be corrupted by software.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

    // Event indices, in arbitration order (0 = highest priority)
    localparam int NUM_EVT  = 4;
    localparam int EV_RCOR  = 0;
    localparam int EV_FCOR  = 1;
    localparam int EV_RUNC  = 2;
    localparam int EV_FUNC  = 3;

    // Register bit positions of each event in the enable/status byte
    localparam int BIT_RCOR = 5;
    localparam int BIT_FCOR = 4;
    localparam int BIT_RUNC = 1;
    localparam int BIT_FUNC = 0;

    typedef enum logic [2:0] {
        RA_ENABLE = 3'd0,
        RA_STATUS = 3'd1,
        RA_RADDR  = 3'd2,
        RA_RINFO  = 3'd3,
        RA_RDATA  = 3'd4,
        RA_FADDR  = 3'd5,
        RA_FINFO  = 3'd6,
        RA_FDATA  = 3'd7
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    // Priority-indexed vector -> register byte
    function automatic logic [7:0] to_layout(input logic [NUM_EVT-1:0] v);
        logic [7:0] b;
        b           = '0;
        b[BIT_RCOR] = v[EV_RCOR];
        b[BIT_FCOR] = v[EV_FCOR];
        b[BIT_RUNC] = v[EV_RUNC];
        b[BIT_FUNC] = v[EV_FUNC];
        return b;
    endfunction

    // Register byte -> priority-indexed vector
    function automatic logic [NUM_EVT-1:0] from_layout(input logic [7:0] b);
        logic [NUM_EVT-1:0] v;
        v[EV_RCOR] = b[BIT_RCOR];
        v[EV_FCOR] = b[BIT_FCOR];
        v[EV_RUNC] = b[BIT_RUNC];
        v[EV_FUNC] = b[BIT_FUNC];
        return v;
    endfunction

endpackage

// File: rtl/ecc_evt_arb.sv
module ecc_evt_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // seen[i] is set when any request below index i is active
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign seen[i+1] = seen[i] | req[i];
        assign grant[i]  = req[i] & ~seen[i];
    end

endmodule

// File: rtl/ecc_flag_regs.sv
module ecc_flag_regs
    import ecc_err_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] en_q,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] acc,
    output logic         irq
);

    irq_state_e   st_q, st_d;
    logic [N-1:0] flag_d;

    assign acc = evt & en_q;

    // An accepted event outranks a clear on the same bit
    always_comb begin
        flag_d = (flag_q & ~clr) | acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= en_wdata;
            end
            flag_q <= flag_d;
        end
    end

    // Next-state logic of the interrupt machine
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: if (|flag_d)        st_d = IRQ_PEND;   // raise
            IRQ_PEND: if (flag_d == '0)   st_d = IRQ_IDLE;   // drop
            default:                      st_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output process
    always_comb begin
        irq = (st_q == IRQ_PEND);
    end

endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
    parameter int AW = 32,
    parameter int IW = 20,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr_i,
    input  logic [IW-1:0] info_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_q,
    output logic [IW-1:0] info_q,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            info_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= addr_i;
            info_q <= info_i;
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
    import ecc_err_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ATTR_W = 8,
    parameter int MSTR_W = 4,
    parameter int SYN_W  = 8,
    parameter int RW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    input  logic              ram_cor,
    input  logic              ram_unc,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [ATTR_W-1:0] ram_attr,
    input  logic [MSTR_W-1:0] ram_mstr,
    input  logic [SYN_W-1:0]  ram_syn,
    input  logic [DATA_W-1:0] ram_data,
    input  logic              fl_cor,
    input  logic              fl_unc,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [ATTR_W-1:0] fl_attr,
    input  logic [MSTR_W-1:0] fl_mstr,
    input  logic [DATA_W-1:0] fl_data,
    output logic              irq
);

    localparam int RINFO_W = SYN_W + MSTR_W + ATTR_W;
    localparam int FINFO_W = MSTR_W + ATTR_W;

    reg_sel_e           sel;
    logic               en_we;
    logic               st_we;
    logic [NUM_EVT-1:0] wr_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] en_vec;
    logic [NUM_EVT-1:0] flag_vec;
    logic [NUM_EVT-1:0] acc_vec;
    logic [NUM_EVT-1:0] grant;
    logic               ram_take;
    logic               fl_take;

    logic [ADDR_W-1:0]  ram_addr_q;
    logic [RINFO_W-1:0] ram_info_q;
    logic [DATA_W-1:0]  ram_data_q;
    logic [ADDR_W-1:0]  fl_addr_q;
    logic [FINFO_W-1:0] fl_info_q;
    logic [DATA_W-1:0]  fl_data_q;

    assign sel     = reg_sel_e'(reg_addr);
    assign en_we   = reg_wr && (sel == RA_ENABLE);
    assign st_we   = reg_wr && (sel == RA_STATUS);
    assign wr_vec  = from_layout(reg_wdata);
    assign clr_vec = st_we ? wr_vec : '0;

    always_comb begin
        evt_vec          = '0;
        evt_vec[EV_RCOR] = ram_cor;
        evt_vec[EV_FCOR] = fl_cor;
        evt_vec[EV_RUNC] = ram_unc;
        evt_vec[EV_FUNC] = fl_unc;
    end

    ecc_flag_regs #(
        .N (NUM_EVT)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (en_we),
        .en_wdata (wr_vec),
        .clr      (clr_vec),
        .evt      (evt_vec),
        .en_q     (en_vec),
        .flag_q   (flag_vec),
        .acc      (acc_vec),
        .irq      (irq)
    );

    // Only enabled events compete for the capture banks
    ecc_evt_arb #(
        .N (NUM_EVT)
    ) u_arb (
        .req   (acc_vec),
        .grant (grant)
    );

    assign ram_take = grant[EV_RCOR] | grant[EV_RUNC];
    assign fl_take  = grant[EV_FCOR] | grant[EV_FUNC];

    ecc_capture #(
        .AW (ADDR_W),
        .IW (RINFO_W),
        .DW (DATA_W)
    ) u_ram_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (ram_take),
        .addr_i (ram_addr),
        .info_i ({ram_syn, ram_mstr, ram_attr}),
        .data_i (ram_data),
        .addr_q (ram_addr_q),
        .info_q (ram_info_q),
        .data_q (ram_data_q)
    );

    ecc_capture #(
        .AW (ADDR_W),
        .IW (FINFO_W),
        .DW (DATA_W)
    ) u_fl_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (fl_take),
        .addr_i (fl_addr),
        .info_i ({fl_mstr, fl_attr}),
        .data_i (fl_data),
        .addr_q (fl_addr_q),
        .info_q (fl_info_q),
        .data_q (fl_data_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_ENABLE: reg_rdata = RW'(to_layout(en_vec));
            RA_STATUS: reg_rdata = RW'(to_layout(flag_vec));
            RA_RADDR:  reg_rdata = RW'(ram_addr_q);
            RA_RINFO:  reg_rdata = RW'(ram_info_q);
            RA_RDATA:  reg_rdata = RW'(ram_data_q);
            RA_FADDR:  reg_rdata = RW'(fl_addr_q);
            RA_FINFO:  reg_rdata = RW'(fl_info_q);
            RA_FDATA:  reg_rdata = RW'(fl_data_q);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_report_chk.sv
module ecc_err_report_chk #(
    parameter int N  = 4,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  en,
    input logic [N-1:0]  flag,
    input logic [N-1:0]  acc,
    input logic [N-1:0]  clr,
    input logic [N-1:0]  grant,
    input logic          irq,
    input logic          ram_take,
    input logic [AW-1:0] ram_addr_q,
    input logic          fl_take,
    input logic [AW-1:0] fl_addr_q
);

    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ~$past(flag) & ~$past(en)) == '0)); // R3

    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flag & $past(flag) & ~$past(clr)) == '0)); // R4

    AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == (flag != '0))); // R5

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != '0) |=> ((flag & $past(acc)) == $past(acc))); // R6

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_take && fl_take)); // R8

    AST_RAM_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_take |=> $stable(ram_addr_q)); // R9

    AST_FL_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_take |=> $stable(fl_addr_q)); // R9

endmodule

bind ecc_err_report ecc_err_report_chk #(
    .N  (ecc_err_pkg::NUM_EVT),
    .AW (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_vec),
    .flag       (flag_vec),
    .acc        (acc_vec),
    .clr        (clr_vec),
    .grant      (grant),
    .irq        (irq),
    .ram_take   (ram_take),
    .ram_addr_q (ram_addr_q),
    .fl_take    (fl_take),
    .fl_addr_q  (fl_addr_q)
);

// File: tb/ecc_err_report_bench.sv
`timescale 1ns/1ps
module ecc_err_report_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ram_cor = 1'b0, ram_unc = 1'b0, fl_cor = 1'b0, fl_unc = 1'b0;
    logic [31:0] ram_addr = '0, ram_data = '0, fl_addr = '0, fl_data = '0;
    logic [7:0]  ram_attr = '0, ram_syn = '0, fl_attr = '0;
    logic [3:0]  ram_mstr = '0, fl_mstr = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Expected capture contents, kept by the bench
    logic [31:0] x_raddr = '0, x_rinfo = '0, x_rdata = '0;
    logic [31:0] x_faddr = '0, x_finfo = '0, x_fdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    ecc_err_report u_ecc_err_report (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_cor(ram_cor), .ram_unc(ram_unc), .ram_addr(ram_addr),
        .ram_attr(ram_attr), .ram_mstr(ram_mstr), .ram_syn(ram_syn),
        .ram_data(ram_data), .fl_cor(fl_cor), .fl_unc(fl_unc),
        .fl_addr(fl_addr), .fl_attr(fl_attr), .fl_mstr(fl_mstr),
        .fl_data(fl_data), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string req, input string what,
                      input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, what, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Load event details for the next pulse
    task automatic set_ram(input logic [31:0] a, input logic [7:0] at,
                           input logic [3:0] m, input logic [7:0] s, input logic [31:0] d);
        ram_addr = a; ram_attr = at; ram_mstr = m; ram_syn = s; ram_data = d;
    endtask

    task automatic set_fl(input logic [31:0] a, input logic [7:0] at,
                          input logic [3:0] m, input logic [31:0] d);
        fl_addr = a; fl_attr = at; fl_mstr = m; fl_data = d;
    endtask

    // One-cycle pulses: {ram_cor, fl_cor, ram_unc, fl_unc}
    task automatic fire(input logic [3:0] k);
        @(negedge clk);
        {ram_cor, fl_cor, ram_unc, fl_unc} = k;
        @(negedge clk);
        {ram_cor, fl_cor, ram_unc, fl_unc} = '0;
    endtask

    task automatic keep_ram();
        x_raddr = ram_addr; x_rinfo = {12'b0, ram_syn, ram_mstr, ram_attr}; x_rdata = ram_data;
    endtask

    task automatic keep_fl();
        x_faddr = fl_addr; x_finfo = {20'b0, fl_mstr, fl_attr}; x_fdata = fl_data;
    endtask

    task automatic check_banks(input string req);
        rd(3'd2, req, "ram addr", x_raddr);
        rd(3'd3, req, "ram info", x_rinfo);
        rd(3'd4, req, "ram data", x_rdata);
        rd(3'd5, req, "flash addr", x_faddr);
        rd(3'd6, req, "flash info", x_finfo);
        rd(3'd7, req, "flash data", x_fdata);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd(3'(a), "R1", "reset reg", 32'h0);
        check("R1", "reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_layout();
        wr(3'd0, 8'hFF);
        rd(3'd0, "R2", "enable readback", 32'h33);
        set_ram(32'h1000_0000, 8'h11, 4'h1, 8'h21, 32'hAAAA_0001);
        fire(4'b1111);
        keep_ram();
        rd(3'd1, "R2", "all flags", 32'h33);
        wr(3'd1, 8'hFF);
        rd(3'd1, "R4", "clear all", 32'h0);
    endtask

    task automatic t_enable_gate();
        wr(3'd0, 8'h00);
        set_ram(32'h2000_0000, 8'h22, 4'h2, 8'h42, 32'hBBBB_0002);
        set_fl(32'h3000_0000, 8'h33, 4'h3, 32'hCCCC_0003);
        fire(4'b1111);
        rd(3'd1, "R3", "disabled flags", 32'h0);
        check("R3", "disabled irq", {31'b0, irq}, 32'h0);
        check_banks("R3");
        wr(3'd0, 8'h20);
        fire(4'b0010);
        rd(3'd1, "R3", "ram unc with only ram cor enabled", 32'h0);
        fire(4'b1000);
        keep_ram();
        rd(3'd1, "R3", "ram cor enabled", 32'h20);
    endtask

    task automatic t_w1c();
        wr(3'd1, 8'h00);
        rd(3'd1, "R4", "write zero", 32'h20);
        wr(3'd1, 8'hDF);
        rd(3'd1, "R4", "write other bits", 32'h20);
        wr(3'd1, 8'h20);
        rd(3'd1, "R4", "write one", 32'h0);
    endtask

    task automatic t_irq_hold();
        wr(3'd0, 8'h33);
        set_ram(32'h4000_0010, 8'h44, 4'h4, 8'h84, 32'hDDDD_0004);
        fire(4'b1000);
        keep_ram();
        @(negedge clk);
        check("R5", "irq after first", {31'b0, irq}, 32'h1);
        set_fl(32'h5000_0020, 8'h55, 4'h5, 32'hEEEE_0005);
        fire(4'b0001);
        keep_fl();
        rd(3'd1, "R5", "two flags", 32'h21);
        wr(3'd1, 8'h20);
        check("R5", "irq after partial clear", {31'b0, irq}, 32'h1);
        wr(3'd1, 8'h01);
        check("R5", "irq after full clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_race();
        fire(4'b1000);
        keep_ram();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h20; ram_cor = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ram_cor = 1'b0;
        #1;
        check("R6", "irq after race", {31'b0, irq}, 32'h1);
        rd(3'd1, "R6", "flag after race", 32'h20);
        wr(3'd1, 8'h20);
        rd(3'd1, "R6", "flag after plain clear", 32'h0);
    endtask

    task automatic t_capture();
        set_ram(32'h6000_1234, 8'hA6, 4'hC, 8'h5E, 32'h0BAD_F00D);
        fire(4'b0010);
        keep_ram();
        check_banks("R7");
        set_fl(32'h7000_5678, 8'h7B, 4'h9, 32'hFEED_BEEF);
        fire(4'b0100);
        keep_fl();
        check_banks("R7");
        set_ram(32'h6000_9999, 8'h01, 4'h3, 8'hC3, 32'h1234_5678);
        fire(4'b1000);
        keep_ram();
        check_banks("R9");
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_priority();
        // flash single-bit outranks RAM uncorrectable
        set_ram(32'h8000_0001, 8'h81, 4'h8, 8'h18, 32'h8888_0001);
        set_fl(32'h9000_0002, 8'h92, 4'h9, 32'h9999_0002);
        fire(4'b0110);
        keep_fl();
        rd(3'd1, "R8", "both flags", 32'h12);
        check_banks("R8");
        wr(3'd1, 8'hFF);
        // RAM single-bit outranks flash uncorrectable
        set_ram(32'hA000_0003, 8'hA3, 4'hA, 8'h3A, 32'hAAAA_0003);
        set_fl(32'hB000_0004, 8'hB4, 4'hB, 32'hBBBB_0004);
        fire(4'b1001);
        keep_ram();
        rd(3'd1, "R8", "both flags second", 32'h21);
        check_banks("R8");
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_readonly();
        for (int a = 2; a < 8; a++) wr(3'(a), 8'hFF);
        check_banks("R10");
        rd(3'd0, "R10", "enable after ro writes", 32'h33);
        rd(3'd1, "R10", "status after ro writes", 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_enable_gate();
        t_w1c();
        t_irq_hold();
        t_race();
        t_capture();
        t_priority();
        t_readonly();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule